// File: doc/BRIEF.md
# Relocation and Limit Protection Unit

This block sits on the path from a processor to memory. Every request that the processor issues in user mode has its logical address checked against a limit register. When the address is in range, the block adds a relocation (base) register to it and forwards the result to memory as a physical address. When the address is out of range, the block sends nothing to memory and raises a trap that carries the offending logical address. Requests issued in supervisor mode pass through unchanged and are not checked.

The base and limit registers are loaded through a small configuration port. A load is accepted only when the port marks it as privileged. An unprivileged load changes nothing and produces a one-cycle fault pulse. Both the processor side and the memory side use a valid/ready handshake. The result of an accepted request, either a memory request or a trap, appears one clock after acceptance. An output register holds that result until memory takes it.

Top module: `reloc_guard`

## Requirements
- R1: A user-mode request (`cpu_req_priv`=0) accepted with logical address A < limit produces, on the next clock, `mem_req_valid`=1 with `mem_req_addr` = A + base and no trap.
- R2: The limit comparison is strict. A user address equal to the limit traps, and an address one below the limit is forwarded.
- R3: `mem_req_addr` is one bit wider than the logical address and keeps the carry of A + base. For example, base 0xFFF0 plus address 0x0020 gives 0x10010.
- R4: A user-mode request with A >= limit issues no memory request. It raises `trap_valid` for exactly one cycle on the next clock, with `trap_addr` = A.
- R5: A supervisor-mode request (`cpu_req_priv`=1) is forwarded on the next clock with `mem_req_addr` = A (upper bit 0), whatever the base and limit, and never traps.
- R6: A configuration write with `cfg_priv`=1 loads the base when `cfg_sel`=0 and the limit when `cfg_sel`=1. A request accepted in the same cycle as the write is still judged with the old values. Requests accepted from the following cycle use the new value.
- R7: A configuration write with `cfg_priv`=0 leaves both registers unchanged and pulses `cfg_fault` for one cycle on the next clock.
- R8: While `mem_req_valid`=1 and `mem_req_ready`=0, the memory request and its address and write flag stay stable, and `cpu_req_ready` is 0. Otherwise `cpu_req_ready` is 1.
- R9: After reset, base and limit are 0, `mem_req_valid`, `trap_valid` and `cfg_fault` are 0, and every user-mode request traps.
- R10: The write flag `cpu_req_we` of a forwarded request appears unchanged on `mem_req_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Writer is in supervisor mode |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_data | input | AW (16) | Value to load |
| cfg_fault | output | 1 | Pulse: unprivileged write rejected |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_addr | input | AW (16) | Logical address |
| cpu_req_we | input | 1 | Request is a write |
| cpu_req_priv | input | 1 | Request is issued in supervisor mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW+1 (17) | Physical address |
| mem_req_we | output | 1 | Memory request is a write |
| trap_valid | output | 1 | Pulse: protection violation |
| trap_addr | output | AW (16) | Logical address that violated the limit |

## Verification
The hardest case to reach is a configuration write that lands in the same cycle as a request, combined with a stalled output stage. The old and new register values then differ from one cycle to the next, and a request may sit unaccepted for several cycles. The stimulus loads a limit in the exact cycle of a boundary access, and a base in the cycle before another access. It then holds `mem_req_ready` low while a new user request keeps waiting with its valid held. A behavioural model, updated on every edge, tracks which register values each accepted request must see.

// File: rtl/rg_pkg.sv
// Package: shared definitions for the relocation and limit protection unit.
// Assumes: none.
package rg_pkg;
    // Selector values on the configuration port.
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } rg_sel_e;

    // Outcome of a single accepted processor request.
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_FWD   = 2'd1,
        OUT_TRAP  = 2'd2
    } rg_outcome_e;
endpackage

// File: rtl/rg_regfile.sv
// Module: holds the relocation (base) and limit registers and enforces
// privileged loads. An unprivileged load is dropped and reported by a
// one-cycle fault pulse.
// Assumes: synchronous active-low reset; cfg_sel follows rg_pkg::rg_sel_e.
module rg_regfile #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic          cfg_priv,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_data,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] limit_o,
    output logic          fault_o
);
    import rg_pkg::*;

    logic          wr_ok;
    logic          wr_bad;
    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          fault_q;

    // Qualify the write strobe by privilege.
    always_comb begin
        wr_ok  = cfg_valid &&  cfg_priv;
        wr_bad = cfg_valid && !cfg_priv;
    end

    // Load the base or the limit register on a privileged write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (wr_ok) begin
            if (rg_sel_e'(cfg_sel) == SEL_BASE) base_q  <= cfg_data;
            else                                 limit_q <= cfg_data;
        end
    end

    // Register the privilege-fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= wr_bad;
    end

    assign base_o  = base_q;
    assign limit_o = limit_q;
    assign fault_o = fault_q;
endmodule

// File: rtl/rg_xlate.sv
// Module: combinational check and relocation of one logical address.
// User requests are compared strictly against the limit and offset by the
// base. Supervisor requests pass through unchanged.
// Assumes: PW = AW + 1 so the sum keeps its carry.
module rg_xlate #(
    parameter int AW = 16,
    parameter int PW = AW + 1
) (
    input  logic          priv_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] limit_i,
    output logic          legal_o,
    output logic [PW-1:0] phys_o
);
    localparam int EXT = PW - AW;

    logic          in_range;
    logic [PW-1:0] sum;

    // Compare against the limit and form the relocated address.
    always_comb begin
        in_range = addr_i < limit_i;
        sum      = {{EXT{1'b0}}, addr_i} + {{EXT{1'b0}}, base_i};
    end

    // Choose between pass-through and relocation by privilege.
    always_comb begin
        if (priv_i) begin
            legal_o = 1'b1;
            phys_o  = {{EXT{1'b0}}, addr_i};
        end else begin
            legal_o = in_range;
            phys_o  = sum;
        end
    end
endmodule

// File: rtl/rg_outstage.sv
// Module: output register toward memory plus the trap pulse. It accepts a
// request when empty or when memory takes the held request this cycle.
// Assumes: the upstream result is valid in the same cycle as in_valid.
module rg_outstage #(
    parameter int AW = 16,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_legal,
    input  logic [PW-1:0] in_phys,
    input  logic          in_we,
    input  logic [AW-1:0] in_laddr,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [PW-1:0] mem_addr,
    output logic          mem_we,
    output logic          trap_valid,
    output logic [AW-1:0] trap_addr
);
    import rg_pkg::*;

    logic          full_q;
    logic [PW-1:0] addr_q;
    logic          we_q;
    logic          trap_q;
    logic [AW-1:0] taddr_q;
    logic          take;
    rg_outcome_e   outcome;

    // Decide whether to accept and what the accepted request produces.
    always_comb begin
        in_ready = !full_q || mem_ready;
        take     = in_valid && in_ready;
        if (!take)         outcome = OUT_NONE;
        else if (in_legal) outcome = OUT_FWD;
        else               outcome = OUT_TRAP;
    end

    // Track occupancy of the memory-side register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  full_q <= 1'b0;
        else if (outcome == OUT_FWD) full_q <= 1'b1;
        else if (mem_ready)          full_q <= 1'b0;
    end

    // Capture address and write flag of a forwarded request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
        end else if (outcome == OUT_FWD) begin
            addr_q <= in_phys;
            we_q   <= in_we;
        end
    end

    // Raise a one-cycle trap with the offending logical address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q  <= 1'b0;
            taddr_q <= '0;
        end else begin
            trap_q <= (outcome == OUT_TRAP);
            if (outcome == OUT_TRAP) taddr_q <= in_laddr;
        end
    end

    assign mem_valid  = full_q;
    assign mem_addr   = addr_q;
    assign mem_we     = we_q;
    assign trap_valid = trap_q;
    assign trap_addr  = taddr_q;
endmodule

// File: rtl/reloc_guard.sv
// Module: relocation and limit protection unit between processor and memory.
// User requests are checked against the limit and relocated by the base.
// Supervisor requests bypass both. The result appears one clock after
// acceptance.
// Assumes: synchronous active-low reset; one request in flight at a time.
module reloc_guard #(
    parameter int AW = 16,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic          cfg_priv,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_data,
    output logic          cfg_fault,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic          cpu_req_we,
    input  logic          cpu_req_priv,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [PW-1:0] mem_req_addr,
    output logic          mem_req_we,
    output logic          trap_valid,
    output logic [AW-1:0] trap_addr
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          legal;
    logic [PW-1:0] phys;

    rg_regfile #(.AW(AW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_valid(cfg_valid),
        .cfg_priv (cfg_priv),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .base_o   (base_q),
        .limit_o  (limit_q),
        .fault_o  (cfg_fault)
    );

    rg_xlate #(.AW(AW), .PW(PW)) xlate_i (
        .priv_i (cpu_req_priv),
        .addr_i (cpu_req_addr),
        .base_i (base_q),
        .limit_i(limit_q),
        .legal_o(legal),
        .phys_o (phys)
    );

    rg_outstage #(.AW(AW), .PW(PW)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (cpu_req_valid),
        .in_ready  (cpu_req_ready),
        .in_legal  (legal),
        .in_phys   (phys),
        .in_we     (cpu_req_we),
        .in_laddr  (cpu_req_addr),
        .mem_valid (mem_req_valid),
        .mem_ready (mem_req_ready),
        .mem_addr  (mem_req_addr),
        .mem_we    (mem_req_we),
        .trap_valid(trap_valid),
        .trap_addr (trap_addr)
    );
endmodule

// File: rtl/rg_checker.sv
// Module: temporal properties of reloc_guard, attached by bind.
// Assumes: base_q and limit_q are the register values inside the top.
module rg_checker #(
    parameter int AW = 16,
    parameter int PW = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_valid,
    input logic          cfg_priv,
    input logic          cfg_fault,
    input logic          cpu_req_valid,
    input logic          cpu_req_ready,
    input logic [AW-1:0] cpu_req_addr,
    input logic          cpu_req_we,
    input logic          cpu_req_priv,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [PW-1:0] mem_req_addr,
    input logic          mem_req_we,
    input logic          trap_valid,
    input logic [AW-1:0] trap_addr,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] limit_q
);
    logic          acc;
    logic [PW-1:0] want_sum;

    // Form the expected relocated address independently of the datapath.
    always_comb begin
        acc      = cpu_req_valid && cpu_req_ready;
        want_sum = PW'(cpu_req_addr) + PW'(base_q);
    end

    AST_USER_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !cpu_req_priv && (cpu_req_addr < limit_q) |=>
            mem_req_valid && !trap_valid && (mem_req_addr == $past(want_sum))); // R1
    AST_USER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !cpu_req_priv && (cpu_req_addr >= limit_q) |=>
            trap_valid && !mem_req_valid && (trap_addr == $past(cpu_req_addr))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !$past(cpu_req_priv) && $rose(mem_req_valid) |->
            (mem_req_addr >= PW'($past(base_q)))); // R3
    AST_SUPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cpu_req_priv |=>
            mem_req_valid && !trap_valid && (mem_req_addr == PW'($past(cpu_req_addr)))); // R5
    AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_priv |=> cfg_fault && $stable(base_q) && $stable(limit_q)); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R8
    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |-> !cpu_req_ready); // R8
    AST_WE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (cpu_req_priv || (cpu_req_addr < limit_q)) |=>
            (mem_req_we == $past(cpu_req_we))); // R10
    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !$past(acc) |-> 1'b0); // R4
endmodule

bind reloc_guard rg_checker #(.AW(AW), .PW(PW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_priv     (cfg_priv),
    .cfg_fault    (cfg_fault),
    .cpu_req_valid(cpu_req_valid),
    .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr (cpu_req_addr),
    .cpu_req_we   (cpu_req_we),
    .cpu_req_priv (cpu_req_priv),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_req_we   (mem_req_we),
    .trap_valid   (trap_valid),
    .trap_addr    (trap_addr),
    .base_q       (base_q),
    .limit_q      (limit_q)
);

// File: tb/reloc_guard_tb_top.sv
// Bench: cycle-by-cycle behavioural model of reloc_guard, compared at every
// falling edge. Inputs change 1 time unit after the falling edge.
module reloc_guard_tb_top;
    localparam int AW      = 16;
    localparam int PW      = AW + 1;
    localparam int CLK_PER = 10;
    localparam int WDOG    = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0, cfg_priv = 1'b0, cfg_sel = 1'b0;
    logic [AW-1:0] cfg_data = '0;
    logic          cfg_fault;
    logic          cpu_req_valid = 1'b0, cpu_req_we = 1'b0, cpu_req_priv = 1'b0;
    logic          cpu_req_ready;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [PW-1:0] mem_req_addr;
    logic          mem_req_we;
    logic          trap_valid;
    logic [AW-1:0] trap_addr;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    cmp_on = 1'b0;
    string phase = "R9";

    // Reference model state.
    int unsigned m_base = 0, m_limit = 0, m_addr = 0, m_taddr = 0;
    bit          m_val = 0, m_we = 0, m_trap = 0, m_fault = 0;

    reloc_guard #(.AW(AW), .PW(PW)) dut_i (.*);

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int unsigned act, input int unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Model update on each rising edge from the same inputs as the design.
    always @(posedge clk) begin
        bit          acc;
        int unsigned a;
        cycles++;
        if (!rst_n) begin
            m_base = 0; m_limit = 0; m_val = 0; m_we = 0;
            m_trap = 0; m_fault = 0; m_addr = 0;
        end else begin
            acc     = cpu_req_valid && (!m_val || mem_req_ready);
            a       = cpu_req_addr;
            m_fault = cfg_valid && !cfg_priv;
            m_trap  = 0;
            if (acc) begin
                if (cpu_req_priv) begin
                    m_val = 1; m_addr = a; m_we = cpu_req_we;
                end else if (a < m_limit) begin
                    m_val = 1; m_addr = a + m_base; m_we = cpu_req_we;
                end else begin
                    m_val = 0; m_trap = 1; m_taddr = a;
                end
            end else if (mem_req_ready) begin
                m_val = 0;
            end
            if (cfg_valid && cfg_priv) begin
                if (cfg_sel) m_limit = cfg_data;
                else         m_base  = cfg_data;
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(mem_req_valid == m_val, phase, "mem_req_valid", mem_req_valid, m_val);
            if (m_val) begin
                check(mem_req_addr == PW'(m_addr), phase, "mem_req_addr", mem_req_addr, m_addr);
                check(mem_req_we == m_we, phase, "mem_req_we", mem_req_we, m_we);
            end
            check(trap_valid == m_trap, phase, "trap_valid", trap_valid, m_trap);
            if (m_trap)
                check(trap_addr == AW'(m_taddr), phase, "trap_addr", trap_addr, m_taddr);
            check(cfg_fault == m_fault, phase, "cfg_fault", cfg_fault, m_fault);
            check(cpu_req_ready == (!m_val || mem_req_ready), phase, "cpu_req_ready",
                  cpu_req_ready, (!m_val || mem_req_ready));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic cfg(input bit priv, input bit sel, input int unsigned d);
        cfg_valid = 1; cfg_priv = priv; cfg_sel = sel; cfg_data = AW'(d);
        tick();
        cfg_valid = 0;
    endtask

    task automatic req(input int unsigned a, input bit priv, input bit we);
        cpu_req_valid = 1; cpu_req_addr = AW'(a); cpu_req_priv = priv; cpu_req_we = we;
        tick();
        cpu_req_valid = 0;
    endtask

    // Watchdog: an over-long run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > WDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        cmp_on = 1;
        // R9: reset state at the ports, then a user request traps.
        phase = "R9";
        check(!mem_req_valid && !trap_valid && !cfg_fault, "R9", "reset outputs",
              {mem_req_valid, trap_valid, cfg_fault}, 0);
        req(16'h0000, 0, 0);
        tick();
        // R6: privileged loads of base and limit.
        phase = "R6";
        cfg(1, 0, 16'h1000);
        cfg(1, 1, 16'h0100);
        // R1 and R10: in-range user accesses, read and write.
        phase = "R1";
        req(16'h0010, 0, 0);
        req(16'h0050, 0, 1);
        phase = "R10";
        req(16'h0020, 0, 1);
        tick();
        // R2: both sides of the boundary.
        phase = "R2";
        req(16'h00FF, 0, 0);
        req(16'h0100, 0, 0);
        tick();
        // R4: far out-of-range address, back-to-back with a legal one.
        phase = "R4";
        req(16'hFFFF, 0, 1);
        req(16'h0001, 0, 0);
        tick();
        // R5: supervisor accesses bypass checks.
        phase = "R5";
        req(16'hFFFF, 1, 1);
        req(16'h0200, 1, 0);
        tick();
        // R7: unprivileged loads rejected, then a boundary access proves the limit held.
        phase = "R7";
        cfg(0, 1, 16'hFFFF);
        cfg(0, 0, 16'h0000);
        req(16'h0100, 0, 0);
        req(16'h00FF, 0, 0);
        tick();
        // R6: load in the same cycle as an access uses the old limit.
        phase = "R6";
        cfg_valid = 1; cfg_priv = 1; cfg_sel = 1; cfg_data = 16'h0200;
        cpu_req_valid = 1; cpu_req_addr = 16'h0150; cpu_req_priv = 0; cpu_req_we = 0;
        tick();
        cfg_valid = 0;
        tick();
        cpu_req_valid = 0;
        tick();
        // R3: carry out of the relocation sum.
        phase = "R3";
        cfg(1, 0, 16'hFFF0);
        req(16'h0020, 0, 0);
        req(16'h01FF, 0, 1);
        tick();
        // R8: memory stalls while a request waits with valid held.
        phase = "R8";
        mem_req_ready = 0;
        req(16'h0004, 0, 1);
        cpu_req_valid = 1; cpu_req_addr = 16'h0008; cpu_req_priv = 0; cpu_req_we = 0;
        for (int i = 0; i < 4; i++) tick();
        mem_req_ready = 1;
        tick();
        cpu_req_valid = 0;
        for (int i = 0; i < 3; i++) tick();
        // R8: stall with a trap accepted once memory drains.
        mem_req_ready = 0;
        req(16'h0001, 1, 0);
        cpu_req_valid = 1; cpu_req_addr = 16'h0300; cpu_req_priv = 0;
        tick(); tick();
        mem_req_ready = 1;
        tick();
        cpu_req_valid = 0;
        tick(); tick();
        // R9: reset in mid-run clears the registers again.
        phase = "R9";
        rst_n = 0;
        tick();
        rst_n = 1;
        req(16'h0000, 0, 0);
        tick();
        cmp_on = 0;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule